// File: doc/BRIEF.md
# 32-bit Arithmetic-Logic Unit with Set-Less-Than

This block is the arithmetic-logic unit of a single-cycle processor datapath. It is purely combinational. It takes two operand words and a 4-bit operation select. It returns a result word, a flag that is high when the result is all zeros, and a flag for signed overflow. The zero flag lets the branch logic test two registers for equality by subtracting them.

One shared adder serves addition, subtraction and both set-less-than forms. For a subtract or a compare, the adder inverts the second operand and sets the carry-in. A separate bitwise unit computes AND, OR, XOR and NOR. The set-less-than operations return a whole word that holds either 0 or 1. The signed compare stays correct even when the internal difference overflows. The overflow flag is reported only for the signed add and signed subtract codes. The unsigned add and subtract codes produce the same sum without that flag, so the decoder can use them for the forms that ignore overflow.

Top module: `alu32_core`

## Requirements
- R1: Select 4'b0000 (signed add) and 4'b1000 (unsigned add) both give result = A + B modulo 2^32.
- R2: Select 4'b0001 (signed subtract) and 4'b1001 (unsigned subtract) both give result = A - B modulo 2^32.
- R3: Select 4'b0010 gives A AND B, 4'b0011 gives A OR B, 4'b0100 gives A XOR B, and 4'b0101 gives NOT (A OR B).
- R4: Select 4'b0110 gives result 1 when A is less than B as two's-complement numbers and 0 otherwise. This holds even when A - B overflows.
- R5: Select 4'b0111 gives result 1 when A is less than B as unsigned numbers and 0 otherwise.
- R6: The zero flag is 1 exactly when all 32 result bits are 0, for every select code.
- R7: For select 4'b0000 the overflow flag is 1 exactly when A and B have the same sign bit and the result's sign bit differs from A's.
- R8: For select 4'b0001 the overflow flag is 1 exactly when A and B have different sign bits and the result's sign bit differs from A's.
- R9: For every select other than 4'b0000 and 4'b0001, the overflow flag is 0. This includes the unsigned add, the unsigned subtract and both compares.
- R10: Select codes 4'b1010 through 4'b1111 are undefined. They give a result of 0, so the zero flag is 1 and the overflow flag is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation select code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Operation result |
| zero_flag | output | 1 | High when result is all zeros |
| ovf_flag | output | 1 | Signed overflow of the signed add and subtract codes |

## Verification
Every output of this block is combinational, so the result, the zero flag and the overflow flag are all due in the same cycle that the select and operands are applied; none waits for a clock edge. The bench applies each vector just after a rising edge and compares all three outputs at the following falling edge, half a period later, when the values have long settled and no edge is near. Vectors cover random operands on every code, the undefined codes, the most negative value, equal operands, and the compare cases where the difference overflows.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_AND  = 4'b0010,
    OP_OR   = 4'b0011,
    OP_XOR  = 4'b0100,
    OP_NOR  = 4'b0101,
    OP_SLT  = 4'b0110,
    OP_SLTU = 4'b0111,
    OP_ADDU = 4'b1000,
    OP_SUBU = 4'b1001
  } alu_op_e;

  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2,
    BW_NOR = 2'd3
  } bw_fn_e;

  // Adder runs in subtract mode (invert B, carry in 1)
  function automatic logic uses_subtract(input logic [OP_W-1:0] op);
    return (op == OP_SUB) || (op == OP_SUBU) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

  // Overflow is reported to the outside only for the signed forms
  function automatic logic reports_overflow(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_SUB);
  endfunction

  function automatic logic is_arith(input logic [OP_W-1:0] op);
    return (op == OP_ADD) || (op == OP_ADDU) || (op == OP_SUB) || (op == OP_SUBU);
  endfunction

  function automatic logic is_bitwise(input logic [OP_W-1:0] op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOR);
  endfunction

  function automatic logic is_compare(input logic [OP_W-1:0] op);
    return (op == OP_SLT) || (op == OP_SLTU);
  endfunction

  function automatic bw_fn_e bitwise_fn(input logic [OP_W-1:0] op);
    case (op)
      OP_AND:  return BW_AND;
      OP_OR:   return BW_OR;
      OP_XOR:  return BW_XOR;
      default: return BW_NOR;
    endcase
  endfunction

  // Two's-complement overflow of a + b_eff, from the three sign bits
  function automatic logic add_overflow(input logic a_msb, input logic b_msb,
                                        input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // Signed less-than from a subtraction: sign of difference corrected by overflow
  function automatic logic signed_less(input logic diff_msb, input logic ovf);
    return diff_msb ^ ovf;
  endfunction

  // Unsigned less-than from a subtraction: no carry out means a borrow
  function automatic logic unsigned_less(input logic carry_out);
    return ~carry_out;
  endfunction

endpackage

// File: rtl/alu32_adder.sv
module alu32_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             ovf_raw
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  always_comb begin
    b_eff   = b ^ {WIDTH{sub}};
    full    = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
    sum     = full[MSB:0];
    carry_out = full[WIDTH];
    ovf_raw = alu32_pkg::add_overflow(a[MSB], b_eff[MSB], full[MSB]);
  end
endmodule

// File: rtl/alu32_bitwise.sv
module alu32_bitwise #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]     a,
  input  logic [WIDTH-1:0]     b,
  input  alu32_pkg::bw_fn_e    fn,
  output logic [WIDTH-1:0]     y
);
  import alu32_pkg::*;

  always_comb begin
    case (fn)
      BW_AND:  y = a & b;
      BW_OR:   y = a | b;
      BW_XOR:  y = a ^ b;
      default: y = ~(a | b);
    endcase
  end
endmodule

// File: rtl/alu32_compare.sv
module alu32_compare (
  input  logic diff_msb,
  input  logic ovf_raw,
  input  logic carry_out,
  input  logic unsigned_mode,
  output logic lt
);
  always_comb begin
    if (unsigned_mode) lt = alu32_pkg::unsigned_less(carry_out);
    else               lt = alu32_pkg::signed_less(diff_msb, ovf_raw);
  end
endmodule

// File: rtl/alu32_core.sv
module alu32_core #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag,
  output logic             ovf_flag
);
  import alu32_pkg::*;

  localparam int MSB = WIDTH - 1;

  // Named internal events for the checker
  logic             sub_mode;
  logic             raw_ovf;
  logic             carry_out;
  logic             lt_bit;
  logic [WIDTH-1:0] sum_word;
  logic [WIDTH-1:0] bw_word;
  bw_fn_e           bw_fn;

  assign sub_mode = uses_subtract(op_sel);
  assign bw_fn    = bitwise_fn(op_sel);

  alu32_adder #(.WIDTH(WIDTH)) u_adder (
    .a         (opnd_a),
    .b         (opnd_b),
    .sub       (sub_mode),
    .sum       (sum_word),
    .carry_out (carry_out),
    .ovf_raw   (raw_ovf)
  );

  alu32_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a  (opnd_a),
    .b  (opnd_b),
    .fn (bw_fn),
    .y  (bw_word)
  );

  alu32_compare u_compare (
    .diff_msb      (sum_word[MSB]),
    .ovf_raw       (raw_ovf),
    .carry_out     (carry_out),
    .unsigned_mode (op_sel == OP_SLTU),
    .lt            (lt_bit)
  );

  always_comb begin
    if (is_arith(op_sel))        result = sum_word;
    else if (is_bitwise(op_sel)) result = bw_word;
    else if (is_compare(op_sel)) result = {{(WIDTH-1){1'b0}}, lt_bit};
    else                         result = '0;
  end

  assign zero_flag = ~|result;
  assign ovf_flag  = raw_ovf & reports_overflow(op_sel);

endmodule

// File: rtl/alu32_core_chk.sv
module alu32_core_chk #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [WIDTH-1:0] result,
  input logic             zero_flag,
  input logic             ovf_flag,
  input logic             sub_mode
);
  import alu32_pkg::*;

  localparam int MSB = WIDTH - 1;

  always_comb begin
    // R6
    zero_match_chk: assert (!zero_flag || (result == '0))
      else $error("zero flag set with nonzero result");
    // R9
    no_overflow_chk: assert (!ovf_flag || (op_sel == OP_ADD) || (op_sel == OP_SUB))
      else $error("overflow flag on a code that never reports it");
    // R7
    ovf_sign_chk: assert (!ovf_flag || (result[MSB] != opnd_a[MSB]))
      else $error("overflow with result sign equal to first operand sign");
    // R4
    slt_word_chk: assert (!((op_sel == OP_SLT) || (op_sel == OP_SLTU)) || (result[MSB:1] == '0))
      else $error("compare result is not a 0/1 word");
    // R5
    cmp_sub_chk: assert (!((op_sel == OP_SLT) || (op_sel == OP_SLTU)) || sub_mode)
      else $error("compare without subtract mode");
    // R10
    undef_zero_chk: assert ((op_sel < 4'b1010) || ((result == '0) && !ovf_flag))
      else $error("undefined code gave nonzero output");
    // R3
    and_mask_chk: assert ((op_sel != OP_AND) || ((result & ~opnd_a) == '0))
      else $error("AND result has bits outside first operand");
    // R3
    nor_mask_chk: assert ((op_sel != OP_NOR) || ((result & (opnd_a | opnd_b)) == '0))
      else $error("NOR result overlaps an operand bit");
  end
endmodule

bind alu32_core alu32_core_chk #(.WIDTH(WIDTH)) u_chk (
  .op_sel    (op_sel),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .result    (result),
  .zero_flag (zero_flag),
  .ovf_flag  (ovf_flag),
  .sub_mode  (sub_mode)
);

// File: tb/alu32_core_test.sv
module alu32_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = 4'd0;
  logic [31:0] opnd_a = 32'd0;
  logic [31:0] opnd_b = 32'd0;
  logic [31:0] result;
  logic        zero_flag;
  logic        ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  alu32_core uut (
    .op_sel    (op_sel),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag)
  );

  // Behavioural reference with wide integer arithmetic
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic v);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint s;
    v = 1'b0;
    case (op)
      4'b0000: begin s = sa + sb; r = 32'(s); v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'b0001: begin s = sa - sb; r = 32'(s); v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'b1000: r = 32'(longint'(a) + longint'(b));
      4'b1001: r = 32'(longint'(a) - longint'(b));
      4'b0010: r = a & b;
      4'b0011: r = a | b;
      4'b0100: r = a ^ b;
      4'b0101: r = ~(a | b);
      4'b0110: r = (sa < sb) ? 32'd1 : 32'd0;
      4'b0111: r = (a < b) ? 32'd1 : 32'd0;
      default: r = 32'd0;
    endcase
  endtask

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'b0000, 4'b1000: return "R1";
      4'b0001, 4'b1001: return "R2";
      4'b0010, 4'b0011, 4'b0100, 4'b0101: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      default: return "R10";
    endcase
  endfunction

  function automatic string ovf_tag(input logic [3:0] op);
    if (op == 4'b0000) return "R7";
    if (op == 4'b0001) return "R8";
    if (op >= 4'b1010) return "R10";
    return "R9";
  endfunction

  task automatic compare(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%b a=%h b=%h actual=%h expected=%h",
               tag, what, op_sel, opnd_a, opnd_b, act, exp);
    end
  endtask

  // Apply after a rising edge; outputs are combinational, checked at the falling edge
  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic        ev;
    @(posedge clk);
    #1;
    op_sel = op; opnd_a = a; opnd_b = b;
    model(op, a, b, er, ev);
    @(negedge clk);
    compare(res_tag(op), "result", result, er);
    compare("R6", "zero", {31'd0, zero_flag}, {31'd0, er == 32'd0});
    compare(ovf_tag(op), "overflow", {31'd0, ovf_flag}, {31'd0, ev});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Quiescent state: add of zeros gives zero result, zero flag high (R1, R6)
    compare("R1", "initial result", result, 32'd0);
    compare("R6", "initial zero", {31'd0, zero_flag}, 32'd1);
    compare("R7", "initial overflow", {31'd0, ovf_flag}, 32'd0);

    // Corner cases
    apply(4'b0000, 32'h7fffffff, 32'h00000001);  // R7 positive overflow
    apply(4'b0000, 32'h80000000, 32'h80000000);  // R7 negative overflow, zero result
    apply(4'b1000, 32'h7fffffff, 32'h00000001);  // R9 unsigned add: no flag
    apply(4'b0001, 32'h80000000, 32'h00000001);  // R8 overflow
    apply(4'b0001, 32'h7fffffff, 32'hffffffff);  // R8 overflow
    apply(4'b1001, 32'h80000000, 32'h00000001);  // R9 unsigned sub: no flag
    apply(4'b0001, 32'h12345678, 32'h12345678);  // R2/R6 equal operands
    apply(4'b0110, 32'h80000000, 32'h00000001);  // R4 most negative < 1
    apply(4'b0110, 32'h7fffffff, 32'h80000000);  // R4 difference overflows: result 0
    apply(4'b0110, 32'h80000000, 32'h7fffffff);  // R4 difference overflows: result 1
    apply(4'b0110, 32'h80000000, 32'h80000000);  // R4 equal operands
    apply(4'b0111, 32'h80000000, 32'h00000001);  // R5 large unsigned: 0
    apply(4'b0111, 32'h00000001, 32'h80000000);  // R5: 1
    apply(4'b0111, 32'hffffffff, 32'hffffffff);  // R5 equal
    apply(4'b0101, 32'hffffffff, 32'h00000000);  // R3 NOR to zero
    apply(4'b0010, 32'hf0f0f0f0, 32'h0f0f0f0f);  // R3 AND to zero
    for (int c = 10; c < 16; c++) apply(4'(c), 32'hdeadbeef, 32'h80000000); // R10

    // Randomised operands on every code, with biased sign bits
    for (int op = 0; op < 16; op++) begin
      for (int n = 0; n < 200; n++) begin
        logic [31:0] ra = $urandom;
        logic [31:0] rb = $urandom;
        if (n % 7 == 0) rb = ra;
        if (n % 11 == 0) ra = 32'h80000000;
        apply(4'(op), ra, rb);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule